// File: doc/BRIEF.md
# Error Event Interrupt and Counter Unit

This unit collects thirteen independent error indications from a serial-bus target controller. Each indication is a pulse one clock wide. For every source the unit keeps five items: a pending status bit, an interrupt enable bit, a self-clearing force bit, a detection gate bit and an 8-bit saturating event counter. A simple single-cycle register port reaches all of them. The unit drives one aggregated interrupt line and a sticky protocol-error flag. Only a chosen subset of the sources sets that flag.

Error input `err_pulse_i[i]` maps to register bit position `i+1` in the status, enable, force and detection-gate words. Bit 0 of each of those words is unused and reads 0. Register addresses are as follows:

- 0: status, write-1-to-clear
- 1: interrupt enable
- 2: force
- 3: detection gate
- 4: protocol flag in bit 0, write-1-to-clear
- `8 + p`: counter for the source at bit position `p`, so addresses 9 to 21

Reads are combinational from the address. A write takes effect at the clock edge on which `reg_we` is high.

Top module: `err_event_unit`

## Requirements
- R1: A pulse on input i that passes the detection gate sets status bit i+1 at the next clock edge. This happens whatever the enable bit holds. Status bit 0 and the bits above 13 always read 0.
- R2: Writing to address 0 clears each status bit written as 1. Bits written as 0 keep their value. A bit whose source pulses in the same cycle as its clear write stays set.
- R3: Writing 1 to bit p at address 2 makes force bit p read 1 for exactly one cycle and then 0. Status bit p becomes set one clock edge after that. Force never changes a counter.
- R4: `irq_o` is high exactly when some status bit has its enable bit at address 1 set, or when any bit of `ext_irq_i` is high. A pending status bit whose enable is clear does not raise `irq_o`.
- R5: Each gated pulse increments the counter for its source by one. Once the counter holds 0xFF it stays at 0xFF under further pulses.
- R6: A write to a counter address loads the counter with `reg_wdata[7:0]`, so writing 0 clears it. If a pulse for the same source arrives in the same cycle, the written value wins.
- R7: Counters count gated pulses whatever the interrupt enable bits hold.
- R8: The detection gate bits at address 3 reset to 1 at positions 1 to 13, so the word reads 0x3FFE. Clearing gate bit p blocks its source completely: the status bit, the counter and the protocol flag all stay unchanged.
- R9: The protocol flag, bit 0 of address 4, is set by a gated pulse on input 1, 2 or 6 (bit positions 2, 3 and 7). Other sources leave it unchanged. Once set, it stays set until 1 is written to bit 0 of address 4. Writing 0 leaves it set.
- R10: After reset, the status, enable, force, protocol flag and all counters read 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pulse_i | input | 13 | Single-cycle error pulses, one per source |
| ext_irq_i | input | 2 | Other interrupt requests merged into irq_o |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 1 | Aggregated interrupt |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the unit with its default parameters: thirteen sources, 8-bit counters and two external interrupt inputs. These sizes are small enough for the bench to walk every source through pulse, status, counter, protocol-flag and clear steps, and then through the force path one source at a time. With 8-bit counters, saturation takes only a few hundred cycles, so a long burst on one source reaches the 0xFF hold. That counter is then reloaded next to the limit. The same-cycle collisions are driven directly: a counter write against a pulse, and a status clear against a pulse. So is a blocked source whose pulse must leave its status bit, counter and protocol flag untouched.

// File: rtl/err_event_unit.sv
module err_event_unit #(
  parameter int NUM_ERR   = 13,
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int EXT_IRQ_W = 2,
  parameter logic [NUM_ERR-1:0] PROTO_SRC = 13'h0046
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ERR-1:0]   err_pulse_i,
  input  logic [EXT_IRQ_W-1:0] ext_irq_i,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_o,
  output logic                 proto_err_o
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DETECT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PROTO  = ADDR_W'(4);
  localparam int                CNT_BASE = 8;
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

  logic [NUM_ERR-1:0] status_q, enable_q, force_q, detect_q, hit, wfield;
  logic               proto_q;
  logic [CNT_W-1:0]   cnt_q [NUM_ERR];
  logic               wr_stat, wr_en, wr_force, wr_det, proto_clr;
  logic               unused_wdata;

  assign wfield    = reg_wdata[NUM_ERR:1];
  assign unused_wdata = ^{reg_wdata};
  assign hit       = err_pulse_i & detect_q;
  assign wr_stat   = reg_we && reg_addr == A_STATUS;
  assign wr_en     = reg_we && reg_addr == A_ENABLE;
  assign wr_force  = reg_we && reg_addr == A_FORCE;
  assign wr_det    = reg_we && reg_addr == A_DETECT;
  assign proto_clr = reg_we && reg_addr == A_PROTO && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      force_q  <= '0;
      detect_q <= '1;
      proto_q  <= 1'b0;
    end else begin
      status_q <= (status_q & ~(wr_stat ? wfield : '0)) | hit | force_q;
      force_q  <= wr_force ? wfield : '0;
      if (wr_en)  enable_q <= wfield;
      if (wr_det) detect_q <= wfield;
      proto_q  <= (proto_q & ~proto_clr) | (|(hit & PROTO_SRC));
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
    logic cnt_wr;
    assign cnt_wr = reg_we && reg_addr == ADDR_W'(CNT_BASE + g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q[g] <= '0;
      else if (cnt_wr)                       cnt_q[g] <= reg_wdata[CNT_W-1:0];
      else if (hit[g] && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && hit[g] && cnt_q[g] != CNT_MAX) |=> cnt_q[g] == CNT_W'($past(cnt_q[g]) + 1'b1));
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && cnt_q[g] == CNT_MAX) |=> cnt_q[g] == CNT_MAX);
    p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_q[g] == $past(reg_wdata[CNT_W-1:0]));
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_STATUS: reg_rdata[NUM_ERR:1] = status_q;
      A_ENABLE: reg_rdata[NUM_ERR:1] = enable_q;
      A_FORCE:  reg_rdata[NUM_ERR:1] = force_q;
      A_DETECT: reg_rdata[NUM_ERR:1] = detect_q;
      A_PROTO:  reg_rdata[0]         = proto_q;
      default: begin
        for (int k = 0; k < NUM_ERR; k++)
          if (reg_addr == ADDR_W'(CNT_BASE + k + 1)) reg_rdata[CNT_W-1:0] = cnt_q[k];
      end
    endcase
  end

  assign irq_o       = (|(status_q & enable_q)) | (|ext_irq_i);
  assign proto_err_o = proto_q;

  p_status_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> (status_q & $past(hit)) == $past(hit));
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && hit == '0 && force_q == '0) |=> (status_q & $past(wfield)) == '0);
  p_force_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_force |=> force_q == '0);
  p_force_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|force_q) |=> (status_q & $past(force_q)) == $past(force_q));
  p_proto_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_q && !proto_clr) |=> proto_q);
  p_proto_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_q && (hit & PROTO_SRC) == '0) |=> !proto_q);

endmodule

// File: tb/err_event_unit_tb.sv
module err_event_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] err_pulse_i = '0;
  logic [1:0]  ext_irq_i = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, proto_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  err_event_unit u_dut (
    .clk(clk), .rst_n(rst_n), .err_pulse_i(err_pulse_i), .ext_irq_i(ext_irq_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .proto_err_o(proto_err_o)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(logic [12:0] v);
    @(negedge clk);
    err_pulse_i = v;
    @(negedge clk);
    err_pulse_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, v); check("R10 status reset", v, 0);
    rd(1, v); check("R10 enable reset", v, 0);
    rd(2, v); check("R10 force reset", v, 0);
    rd(4, v); check("R10 proto reset", v, 0);
    check("R10 irq reset", {31'd0, irq_o}, 0);
    rd(3, v); check("R8 detect reset", v, 32'h3FFE);
    for (int k = 0; k < 13; k++) begin
      rd(5'(9 + k), v); check("R10 counter reset", v, 0);
    end

    for (int i = 0; i < 13; i++) begin
      pulse(13'(1) << i);
      rd(0, v); check("R1 status set", v, 32'(1) << (i + 1));
      check("R4 irq disabled", {31'd0, irq_o}, 0);
      rd(5'(9 + i), v); check("R5 count one", v, 1);
      rd(4, v); check("R9 proto subset", v, (i == 1 || i == 2 || i == 6) ? 1 : 0);
      check("R9 proto pin", {31'd0, proto_err_o}, (i == 1 || i == 2 || i == 6) ? 1 : 0);
      wr(0, 32'(1) << (i + 1));
      rd(0, v); check("R2 w1c", v, 0);
      wr(4, 1);
    end

    for (int i = 0; i < 13; i++) begin
      wr(2, 32'(1) << (i + 1));
      rd(2, v); check("R3 force visible", v, 32'(1) << (i + 1));
      rd(0, v); check("R3 status not yet", v, 0);
      @(negedge clk);
      rd(0, v); check("R3 status forced", v, 32'(1) << (i + 1));
      rd(2, v); check("R3 force cleared", v, 0);
      rd(5'(9 + i), v); check("R3 counter untouched", v, 1);
      wr(0, 32'(1) << (i + 1));
    end

    pulse(13'h0028);
    rd(0, v); check("R1 two sources", v, 32'h50);
    wr(0, 0);
    rd(0, v); check("R2 write zero", v, 32'h50);
    wr(0, 32'h10);
    rd(0, v); check("R2 partial clear", v, 32'h40);
    wr(0, 32'h40);

    wr(1, 32'h20);
    rd(1, v); check("R4 enable readback", v, 32'h20);
    pulse(13'h0010);
    check("R4 irq enabled", {31'd0, irq_o}, 1);
    pulse(13'h0001);
    wr(0, 32'h20);
    rd(0, v); check("R4 other pending", v, 32'h2);
    check("R4 irq masked", {31'd0, irq_o}, 0);
    ext_irq_i = 2'b10;
    #1 check("R4 external irq", {31'd0, irq_o}, 1);
    ext_irq_i = 2'b00;
    #1 check("R4 external off", {31'd0, irq_o}, 0);
    rd(5'(9), v); check("R7 count without enable", v, 2);
    rd(5'(13), v); check("R7 count with enable", v, 2);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 0);

    @(negedge clk);
    err_pulse_i = 13'(1) << 9;
    repeat (300) @(negedge clk);
    err_pulse_i = '0;
    rd(5'(18), v); check("R5 saturate", v, 32'hFF);
    pulse(13'(1) << 9);
    rd(5'(18), v); check("R5 hold at max", v, 32'hFF);
    wr(5'(18), 32'h1FE);
    rd(5'(18), v); check("R6 load", v, 32'hFE);
    pulse(13'(1) << 9);
    rd(5'(18), v); check("R5 step to max", v, 32'hFF);
    wr(5'(18), 0);
    rd(5'(18), v); check("R6 clear", v, 0);

    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(18); reg_wdata = 32'h40; err_pulse_i = 13'(1) << 9;
    @(negedge clk);
    reg_we = 1'b0; err_pulse_i = '0;
    rd(5'(18), v); check("R6 write wins", v, 32'h40);

    @(negedge clk);
    reg_we = 1'b1; reg_addr = 0; reg_wdata = 32'(1) << 10; err_pulse_i = 13'(1) << 9;
    @(negedge clk);
    reg_we = 1'b0; err_pulse_i = '0;
    rd(0, v); check("R2 set beats clear", v, 32'(1) << 10);
    wr(0, 32'(1) << 10);

    wr(3, 32'h3FFE & ~32'h8);
    rd(3, v); check("R8 detect readback", v, 32'h3FF6);
    pulse(13'(1) << 2);
    rd(0, v); check("R8 gated status", v, 0);
    rd(5'(11), v); check("R8 gated counter", v, 1);
    rd(4, v); check("R8 gated proto", v, 0);
    wr(3, 32'h3FFE);
    pulse(13'(1) << 2);
    rd(5'(11), v); check("R8 regated counter", v, 2);
    wr(4, 1);

    pulse(13'(1) << 6);
    rd(4, v); check("R9 proto set", v, 1);
    pulse(13'(1) << 8);
    rd(4, v); check("R9 sticky", v, 1);
    wr(4, 0);
    rd(4, v); check("R9 write zero", v, 1);
    wr(4, 1);
    rd(4, v); check("R9 cleared", v, 0);
    check("R9 pin cleared", {31'd0, proto_err_o}, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check("R2 clear all", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule